// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel buses, A and B, with one independent path in each direction. Each path has its own capture register and capture clock, its own source select and its own output enable. A path forwards either the live value on its source bus or the word last captured in its register. The forwarded value is always bit-inverted.

The buses are modelled as separate input, output and per-bit output-enable vectors rather than tri-state nets. The surrounding logic resolves each bus. With both enables off the block only stores data. With both on, it can return a held word onto one bus while live data passes the other way.

A contention flag marks the one combination that forms a combinational loop through the two buses. That combination is both paths enabled with both selecting live data.

Top module: `dual_path_xcvr`

## Requirements
- R1: The A-side register captures `a_in` on each rising edge of `clk_ab` and keeps its value at all other times, including across rising edges of `clk_ba`.
- R2: The B-side register captures `b_in` on each rising edge of `clk_ba` and keeps its value at all other times, including across rising edges of `clk_ab`.
- R3: While `rst_n` is low, both registers are zero, and this takes effect without any clock edge.
- R4: When `en_ab` is 1, `b_oe` is all ones. `b_out` is then the bitwise complement of `a_in` when `sel_ab` is 0, and the complement of the A-side register when `sel_ab` is 1.
- R5: When `en_ba_n` is 0, `a_oe` is all ones. `a_out` is then the bitwise complement of `b_in` when `sel_ba` is 0, and the complement of the B-side register when `sel_ba` is 1.
- R6: When `en_ab` is 0, `b_oe` is all zeros. When `en_ba_n` is 1, `a_oe` is all zeros. The registers keep capturing on their clocks while their paths are disabled.
- R7: Selects, enables and live bus inputs reach the outputs combinationally, with no clock edge needed.
- R8: `clash` is 1 exactly when `en_ab` is 1, `en_ba_n` is 0, `sel_ab` is 0 and `sel_ba` is 0. Otherwise it is 0.
- R9: When both capture clocks rise together, both registers capture their respective buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-side register |
| clk_ba | input | 1 | Capture clock of the B-side register |
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| a_in | input | 8 | Value seen on bus A |
| b_in | input | 8 | Value seen on bus B |
| en_ab | input | 1 | A-to-B drive enable, active high |
| en_ba_n | input | 1 | B-to-A drive enable, active low |
| sel_ab | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live, 1 stored |
| b_out | output | 8 | Value offered to bus B |
| b_oe | output | 8 | Per-bit drive enable for bus B |
| a_out | output | 8 | Value offered to bus A |
| a_oe | output | 8 | Per-bit drive enable for bus A |
| clash | output | 1 | Both paths enabled in live mode |

## Verification
The bench clocks one register while changing the other bus. A design that shared or crossed the capture clocks would show the wrong stored word on the held path. It pulses both clocks together, which catches a register that loses one of two simultaneous loads. It alters selects, enables and live inputs with no clock, so a design that registered the output stage would lag by one edge. It also checks that the opposite polarities of the two enables are honoured, that a disabled path still captures data, and that asynchronous reset and the contention flag behave as required for every select combination.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STORED = 1'b1
   } src_e;

   localparam int unsigned MIN_WIDTH = 1;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < xcvr_pkg::MIN_WIDTH) begin : g_bad_width
      $error("xcvr_store: width must be at least one bit");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

   // R1 / R2: the word seen at an edge is what the register holds after it
   a_r1_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (q == $past(d)));
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
   parameter int unsigned W        = 8,
   parameter bit          INVERT   = 1'b1,
   parameter bit          EN_LOW   = 1'b0
) (
   input  logic         en_pin,
   input  xcvr_pkg::src_e sel,
   input  logic [W-1:0] live,
   input  logic [W-1:0] stored,
   output logic [W-1:0] out,
   output logic [W-1:0] oe,
   output logic         drive
);
   import xcvr_pkg::*;

   if (W < MIN_WIDTH) begin : g_bad_width
      $error("xcvr_lane: width must be at least one bit");
   end

   logic [W-1:0] picked;
   logic [W-1:0] shaped;

   if (EN_LOW) begin : g_en_low
      assign drive = ~en_pin;
   end else begin : g_en_high
      assign drive = en_pin;
   end

   always_comb begin
      picked = (sel == SRC_STORED) ? stored : live;
   end

   if (INVERT) begin : g_inv
      assign shaped = ~picked;
   end else begin : g_pass
      assign shaped = picked;
   end

   assign out = drive ? shaped : '0;
   assign oe  = {W{drive}};
endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr #(
   parameter int unsigned W      = 8,
   parameter bit          INVERT = 1'b1
) (
   input  logic         clk_ab,
   input  logic         clk_ba,
   input  logic         rst_n,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   input  logic         en_ab,
   input  logic         en_ba_n,
   input  logic         sel_ab,
   input  logic         sel_ba,
   output logic [W-1:0] b_out,
   output logic [W-1:0] b_oe,
   output logic [W-1:0] a_out,
   output logic [W-1:0] a_oe,
   output logic         clash
);
   import xcvr_pkg::*;

   if (W < MIN_WIDTH) begin : g_bad_width
      $error("dual_path_xcvr: width must be at least one bit");
   end

   logic [W-1:0] held_ab;
   logic [W-1:0] held_ba;
   logic         drv_ab;
   logic         drv_ba;
   src_e         src_ab;
   src_e         src_ba;

   assign src_ab = src_e'(sel_ab);
   assign src_ba = src_e'(sel_ba);

   xcvr_store #(.W(W)) u_store_ab (
      .clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(held_ab));

   xcvr_store #(.W(W)) u_store_ba (
      .clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(held_ba));

   xcvr_lane #(.W(W), .INVERT(INVERT), .EN_LOW(1'b0)) u_lane_ab (
      .en_pin(en_ab), .sel(src_ab), .live(a_in), .stored(held_ab),
      .out(b_out), .oe(b_oe), .drive(drv_ab));

   xcvr_lane #(.W(W), .INVERT(INVERT), .EN_LOW(1'b1)) u_lane_ba (
      .en_pin(en_ba_n), .sel(src_ba), .live(b_in), .stored(held_ba),
      .out(a_out), .oe(a_oe), .drive(drv_ba));

   assign clash = drv_ab && drv_ba && (src_ab == SRC_LIVE) && (src_ba == SRC_LIVE);

   // R4: stored A-side word reaches bus B inverted
   a_r4_stored_to_b: assert property (@(posedge clk_ba) disable iff (!rst_n)
      (en_ab && sel_ab) |-> (b_out == ~held_ab));
   // R5: live B bus reaches bus A inverted
   a_r5_live_to_a: assert property (@(posedge clk_ab) disable iff (!rst_n)
      (!en_ba_n && !sel_ba) |-> (a_out == ~b_in));
   // R6: enable vectors are all-on or all-off
   a_r6_oe_uniform: assert property (@(posedge clk_ab) disable iff (!rst_n)
      1'b1 |-> ((b_oe == '0 || b_oe == '1) && (a_oe == '0 || a_oe == '1)));
   // R8: flag only with both buses driven
   a_r8_clash_drives: assert property (@(posedge clk_ab) disable iff (!rst_n)
      clash |-> (b_oe == '1 && a_oe == '1));
endmodule

// File: tb/dual_path_xcvr_test.sv
`timescale 1ns/1ps
module dual_path_xcvr_test;
   logic       clk = 1'b0;
   logic       clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
   logic [7:0] a_in = '0, b_in = '0;
   logic       en_ab = 1'b0, en_ba_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
   logic [7:0] b_out, b_oe, a_out, a_oe;
   logic       clash;
   int         checks = 0, errors = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   dual_path_xcvr uut (
      .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
      .en_ab(en_ab), .en_ba_n(en_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
      .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe), .clash(clash));

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic pulse(bit ab, bit ba);
      #2;
      if (ab) clk_ab = 1'b1;
      if (ba) clk_ba = 1'b1;
      #2;
      clk_ab = 1'b0; clk_ba = 1'b0;
      #1;
   endtask

   task automatic t_reset;
      rst_n = 1'b0; #1;
      chk("R6 reset b_oe", b_oe, 8'h00);
      chk("R6 reset a_oe", a_oe, 8'h00);
      en_ab = 1'b1; sel_ab = 1'b1; en_ba_n = 1'b0; sel_ba = 1'b1; #1;
      chk("R3 reset A reg", b_out, 8'hFF);
      chk("R3 reset B reg", a_out, 8'hFF);
      #2 rst_n = 1'b1; #2;
   endtask

   task automatic t_capture_ab;
      en_ab = 1'b1; sel_ab = 1'b1; a_in = 8'h5A; pulse(1, 0);
      chk("R1 capture", b_out, 8'hA5);
      chk("R4 b_oe on", b_oe, 8'hFF);
      a_in = 8'h33; #1;
      chk("R1 hold no edge", b_out, 8'hA5);
      pulse(0, 1);
      chk("R1 hold on clk_ba", b_out, 8'hA5);
   endtask

   task automatic t_live_ab;
      sel_ab = 1'b0; a_in = 8'h0F; #1;
      chk("R4 live", b_out, 8'hF0);
      a_in = 8'hC0; #1;
      chk("R7 live follows", b_out, 8'h3F);
   endtask

   task automatic t_capture_ba;
      en_ba_n = 1'b0; sel_ba = 1'b1; b_in = 8'hC3; pulse(0, 1);
      chk("R2 capture", a_out, 8'h3C);
      chk("R5 a_oe on", a_oe, 8'hFF);
      b_in = 8'h00; pulse(1, 0);
      chk("R2 hold on clk_ab", a_out, 8'h3C);
      sel_ba = 1'b0; b_in = 8'h81; #1;
      chk("R5 live", a_out, 8'h7E);
   endtask

   task automatic t_both;
      sel_ab = 1'b1; sel_ba = 1'b1; a_in = 8'h11; b_in = 8'h22; pulse(1, 1);
      chk("R9 A reg", b_out, 8'hEE);
      chk("R9 B reg", a_out, 8'hDD);
   endtask

   task automatic t_disable;
      en_ab = 1'b0; en_ba_n = 1'b1; #1;
      chk("R6 b_oe off", b_oe, 8'h00);
      chk("R6 a_oe off", a_oe, 8'h00);
      a_in = 8'h99; b_in = 8'h0E; pulse(1, 1);
      en_ab = 1'b1; en_ba_n = 1'b0; #1;
      chk("R6 storage A", b_out, 8'h66);
      chk("R6 storage B", a_out, 8'hF1);
   endtask

   task automatic t_clash;
      for (int k = 0; k < 16; k++) begin
         en_ab = k[0]; en_ba_n = k[1]; sel_ab = k[2]; sel_ba = k[3]; #1;
         chk("R8 clash", {7'd0, clash},
             {7'd0, (k[0] && !k[1] && !k[2] && !k[3])});
      end
   endtask

   task automatic t_async_reset;
      en_ab = 1'b1; en_ba_n = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
      a_in = 8'h3C; b_in = 8'h5A; pulse(1, 1);
      chk("R3 preload", b_out, 8'hC3);
      rst_n = 1'b0; #1;
      chk("R3 async A", b_out, 8'hFF);
      chk("R3 async B", a_out, 8'hFF);
      #2 rst_n = 1'b1; #2;
   endtask

   initial begin
      t_reset();
      t_capture_ab();
      t_live_ab();
      t_capture_ba();
      t_both();
      t_disable();
      t_clash();
      t_async_reset();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule